// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus port of a byte-wide flash model and turns the stream of host write cycles into the device's internal commands. Every command opens with a two-write unlock key: data AAh at address 5555h, then data 55h at address 2AAAh. A third write at 5555h names the operation. Some operations end there (identification mode on or off). Programming needs one more write that carries the target address and byte. Erase and boot protection need a second unlock key followed by a final opcode write.

The decoder sends single-cycle program and erase requests to the status engine that times the operation. It keeps a sticky boot-protection flag and an identification-mode flag. While identification mode is active, it answers reads with the manufacturer code, the device code and the protection state. A parameter places the 16 KB boot region at the bottom or at the top of the address space. Program requests into that region are dropped once protection is on. The array and the operation timer live elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Only the low 15 address bits take part in matching the unlock key (AAh at 5555h, then 55h at 2AAAh) and the opcode writes. Address bits 18..15 of those writes have no effect on decoding.
- R2: After the unlock key and A0h at 5555h, the next write is the program write. In the cycle after that write, prog_pulse_o is 1 for exactly one cycle, and prog_addr_o/prog_data_o hold that write's full 19-bit address and data.
- R3: Unlock key plus 90h at 5555h sets id_mode_o. Unlock key plus F0h at 5555h clears it. A lone write of F0h to any address, made while no sequence is in progress, also clears it.
- R4: Unlock key, 80h at 5555h, a second unlock key, then 10h at 5555h gives erase_pulse_o = 1 for exactly one cycle, in the cycle after the final write.
- R5: The same six-write path with 40h as the last opcode sets lock_o. lock_o stays set until rst_n. While it is set, a program write whose address falls in the boot region gives no pulse; program writes outside the region still give one. With TOP_BOOT = 0 the region is addresses below 04000h; with TOP_BOOT = 1 it is 7C000h and above.
- R6: When rd_en is high and identification mode is on, the next cycle has id_valid_o = 1 and id_data_o = 1Fh for address 0, the device code for address 1 (13h when TOP_BOOT = 0, 12h when TOP_BOOT = 1), and {7'b0, lock_o} for address 2. Every other address gives 00h. Outside identification mode, id_valid_o stays 0.
- R7: A write that does not match the expected address/data pair for the current step returns the decoder to idle. That write does not start a new sequence, and the writes that follow it are decoded from idle.
- R8: A write made while busy_i is 1 is ignored. It changes neither the sequence step nor any flag, and it produces no pulse.
- R9: After reset, id_mode_o, lock_o, prog_pulse_o, erase_pulse_o and id_valid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also clears the protection flag |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 19 | Read address |
| busy_i | input | 1 | Status engine busy; writes are ignored while high |
| prog_pulse_o | output | 1 | One-cycle program request |
| prog_addr_o | output | 19 | Program target address |
| prog_data_o | output | 8 | Program data byte |
| erase_pulse_o | output | 1 | One-cycle chip erase request |
| lock_o | output | 1 | Boot-region protection active |
| id_mode_o | output | 1 | Identification mode active |
| id_valid_o | output | 1 | id_data_o is valid for the previous read |
| id_data_o | output | 8 | Identification read data |

## Verification
The assertions check on every cycle that:
- the protection flag never drops;
- a busy cycle leaves both flags unchanged and produces no pulse;
- program and erase pulses last one cycle;
- no program pulse reaches the boot region while protection is on;
- identification data appears only after a read made in identification mode.

Only the bench scenarios can show the rest: that the exact opcode paths, the ignored high address bits and the lone F0h exit decode as required, that mismatching writes abort a sequence, and that the identification read-back values are correct.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG,
        ST_EXT1,
        ST_EXT2,
        ST_EXT3
    } seq_step_e;

    localparam int BYTE_W = 8;
    localparam int CMP_W  = 15;

    localparam logic [CMP_W-1:0]  ADR_KEY_A = 15'h5555;
    localparam logic [CMP_W-1:0]  ADR_KEY_B = 15'h2AAA;

    localparam logic [BYTE_W-1:0] DAT_KEY_A = 8'hAA;
    localparam logic [BYTE_W-1:0] DAT_KEY_B = 8'h55;
    localparam logic [BYTE_W-1:0] OP_PROG   = 8'hA0;
    localparam logic [BYTE_W-1:0] OP_EXT    = 8'h80;
    localparam logic [BYTE_W-1:0] OP_ID_ON  = 8'h90;
    localparam logic [BYTE_W-1:0] OP_ID_OFF = 8'hF0;
    localparam logic [BYTE_W-1:0] OP_ERASE  = 8'h10;
    localparam logic [BYTE_W-1:0] OP_LOCK   = 8'h40;

endpackage

// File: rtl/fcd_boot_guard.sv
module fcd_boot_guard #(
    parameter int ADDR_W   = 19,
    parameter int BOOT_W   = 14,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [ADDR_W-BOOT_W-1:0] addr_hi,
    output logic                     in_boot
);

    generate
        if (TOP_BOOT) begin : g_top
            always_comb in_boot = &addr_hi;
        end else begin : g_bottom
            always_comb in_boot = ~|addr_hi;
        end
    endgenerate

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              busy_i,
    input  logic              wr_in_boot,
    output logic              prog_pulse_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [BYTE_W-1:0] prog_data_o,
    output logic              erase_pulse_o,
    output logic              lock_o,
    output logic              id_mode_o
);

    typedef struct packed {
        seq_step_e         step;
        logic              id_mode;
        logic              lock;
        logic              prog_pls;
        logic [ADDR_W-1:0] prog_addr;
        logic [BYTE_W-1:0] prog_data;
        logic              erase_pls;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      at_a, at_b;

    always_comb begin
        at_a  = (wr_addr[CMP_W-1:0] == ADR_KEY_A);
        at_b  = (wr_addr[CMP_W-1:0] == ADR_KEY_B);
        seq_d = seq_q;
        seq_d.prog_pls  = 1'b0;
        seq_d.erase_pls = 1'b0;
        if (wr_en && !busy_i) begin
            unique case (seq_q.step)
                ST_IDLE: begin
                    if (at_a && wr_data == DAT_KEY_A) begin
                        seq_d.step = ST_KEY1;
                    end else begin
                        seq_d.step = ST_IDLE;
                        if (wr_data == OP_ID_OFF) seq_d.id_mode = 1'b0;
                    end
                end
                ST_KEY1: begin
                    seq_d.step = (at_b && wr_data == DAT_KEY_B) ? ST_KEY2 : ST_IDLE;
                end
                ST_KEY2: begin
                    seq_d.step = ST_IDLE;
                    if (at_a) begin
                        case (wr_data)
                            OP_PROG:   seq_d.step = ST_PROG;
                            OP_EXT:    seq_d.step = ST_EXT1;
                            OP_ID_ON:  seq_d.id_mode = 1'b1;
                            OP_ID_OFF: seq_d.id_mode = 1'b0;
                            default:   seq_d.step = ST_IDLE;
                        endcase
                    end
                end
                ST_PROG: begin
                    seq_d.step = ST_IDLE;
                    if (!(seq_q.lock && wr_in_boot)) begin
                        seq_d.prog_pls  = 1'b1;
                        seq_d.prog_addr = wr_addr;
                        seq_d.prog_data = wr_data;
                    end
                end
                ST_EXT1: begin
                    seq_d.step = (at_a && wr_data == DAT_KEY_A) ? ST_EXT2 : ST_IDLE;
                end
                ST_EXT2: begin
                    seq_d.step = (at_b && wr_data == DAT_KEY_B) ? ST_EXT3 : ST_IDLE;
                end
                ST_EXT3: begin
                    seq_d.step = ST_IDLE;
                    if (at_a) begin
                        case (wr_data)
                            OP_ERASE: seq_d.erase_pls = 1'b1;
                            OP_LOCK:  seq_d.lock      = 1'b1;
                            default:  seq_d.step      = ST_IDLE;
                        endcase
                    end
                end
                default: seq_d.step = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{step: ST_IDLE, prog_addr: '0, prog_data: '0, default: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign prog_pulse_o  = seq_q.prog_pls;
    assign prog_addr_o   = seq_q.prog_addr;
    assign prog_data_o   = seq_q.prog_data;
    assign erase_pulse_o = seq_q.erase_pls;
    assign lock_o        = seq_q.lock;
    assign id_mode_o     = seq_q.id_mode;

endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 19,
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'h1F,
    parameter logic [BYTE_W-1:0] DEV_CODE = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              id_mode,
    input  logic              lock,
    output logic              id_valid_o,
    output logic [BYTE_W-1:0] id_data_o
);

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rd_regs_t;

    rd_regs_t rd_d, rd_q;

    always_comb begin
        rd_d.valid = rd_en && id_mode;
        rd_d.data  = '0;
        if (rd_d.valid) begin
            case (rd_addr)
                ADDR_W'(0): rd_d.data = MFR_CODE;
                ADDR_W'(1): rd_d.data = DEV_CODE;
                ADDR_W'(2): rd_d.data = {{(BYTE_W-1){1'b0}}, lock};
                default:    rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign id_valid_o = rd_q.valid;
    assign id_data_o  = rd_q.data;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 19,
    parameter int                BOOT_W   = 14,
    parameter bit                TOP_BOOT = 1'b0,
    parameter logic [BYTE_W-1:0] MFR_CODE = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy_i,
    output logic              prog_pulse_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [7:0]        prog_data_o,
    output logic              erase_pulse_o,
    output logic              lock_o,
    output logic              id_mode_o,
    output logic              id_valid_o,
    output logic [7:0]        id_data_o
);

    localparam logic [BYTE_W-1:0] DEV_CODE = TOP_BOOT ? 8'h12 : 8'h13;

    logic wr_in_boot;

    fcd_boot_guard #(
        .ADDR_W   (ADDR_W),
        .BOOT_W   (BOOT_W),
        .TOP_BOOT (TOP_BOOT)
    ) u_guard (
        .addr_hi (wr_addr[ADDR_W-1:BOOT_W]),
        .in_boot (wr_in_boot)
    );

    fcd_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .busy_i        (busy_i),
        .wr_in_boot    (wr_in_boot),
        .prog_pulse_o  (prog_pulse_o),
        .prog_addr_o   (prog_addr_o),
        .prog_data_o   (prog_data_o),
        .erase_pulse_o (erase_pulse_o),
        .lock_o        (lock_o),
        .id_mode_o     (id_mode_o)
    );

    fcd_id_read #(
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_idrd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .id_mode    (id_mode_o),
        .lock       (lock_o),
        .id_valid_o (id_valid_o),
        .id_data_o  (id_data_o)
    );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int ADDR_W   = 19,
    parameter int BOOT_W   = 14,
    parameter bit TOP_BOOT = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              busy_i,
    input logic              prog_pulse_o,
    input logic [ADDR_W-1:0] prog_addr_o,
    input logic              erase_pulse_o,
    input logic              lock_o,
    input logic              id_mode_o,
    input logic              id_valid_o
);

    logic [ADDR_W-BOOT_W-1:0] pa_hi;
    logic                     pa_boot;

    assign pa_hi   = prog_addr_o[ADDR_W-1:BOOT_W];
    assign pa_boot = TOP_BOOT ? (pa_hi == {(ADDR_W-BOOT_W){1'b1}}) : (pa_hi == '0);

    p_prog_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse_o |=> !prog_pulse_o);

    p_erase_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse_o |=> !erase_pulse_o);

    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    p_boot_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_pulse_o && lock_o) |-> !pa_boot);

    p_id_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid_o |-> ($past(rd_en) && $past(id_mode_o)));

    p_busy_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (!prog_pulse_o && !erase_pulse_o && $stable(lock_o) && $stable(id_mode_o)));

endmodule

bind flash_cmd_decoder flash_cmd_checker #(
    .ADDR_W   (ADDR_W),
    .BOOT_W   (BOOT_W),
    .TOP_BOOT (TOP_BOOT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en         (rd_en),
    .busy_i        (busy_i),
    .prog_pulse_o  (prog_pulse_o),
    .prog_addr_o   (prog_addr_o),
    .erase_pulse_o (erase_pulse_o),
    .lock_o        (lock_o),
    .id_mode_o     (id_mode_o),
    .id_valid_o    (id_valid_o)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

    localparam int ADDR_W   = 19;
    localparam bit TOP_BOOT = 1'b0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              busy_i = 1'b0;
    logic              prog_pulse_o;
    logic [ADDR_W-1:0] prog_addr_o;
    logic [7:0]        prog_data_o;
    logic              erase_pulse_o;
    logic              lock_o;
    logic              id_mode_o;
    logic              id_valid_o;
    logic [7:0]        id_data_o;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .busy_i(busy_i),
        .prog_pulse_o(prog_pulse_o), .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
        .erase_pulse_o(erase_pulse_o), .lock_o(lock_o), .id_mode_o(id_mode_o),
        .id_valid_o(id_valid_o), .id_data_o(id_data_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // each call starts at a falling edge and returns at the next one
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic unlock(input logic [3:0] hi);
        wr({hi, 15'h5555}, 8'hAA);
        wr({hi, 15'h2AAA}, 8'h55);
    endtask

    task automatic do_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        unlock(4'h0);
        wr(19'h05555, 8'hA0);
        wr(a, d);
    endtask

    task automatic do_ext(input logic [7:0] op);
        unlock(4'h0);
        wr(19'h05555, 8'h80);
        unlock(4'h0);
        wr(19'h05555, op);
    endtask

    function automatic logic in_boot(input logic [ADDR_W-1:0] a);
        return TOP_BOOT ? (a >= 19'h7C000) : (a < 19'h04000);
    endfunction

    function automatic logic [7:0] id_expect(input logic [ADDR_W-1:0] a, input logic lk);
        if (a == 0) return 8'h1F;
        if (a == 1) return 8'h13 - 8'(TOP_BOOT);
        if (a == 2) return {7'b0, lk};
        return 8'h00;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 id_mode", id_mode_o, 0);
        check("R9 lock", lock_o, 0);
        check("R9 prog_pulse", prog_pulse_o, 0);
        check("R9 erase_pulse", erase_pulse_o, 0);
        check("R9 id_valid", id_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(19'h0);
        check("R9 no id read after reset", id_valid_o, 0);

        // R1/R2: sweep the ignored high address bits of the key writes
        for (int hi = 0; hi < 16; hi++) begin
            logic [ADDR_W-1:0] pa;
            logic [7:0]        pd;
            pa = 19'h10000 + ADDR_W'(hi * 37);
            pd = 8'h5A ^ 8'(hi * 3);
            unlock(4'(hi));
            wr({4'(15 - hi), 15'h5555}, 8'hA0);
            wr(pa, pd);
            check("R1/R2 prog pulse", prog_pulse_o, 1);
            check("R2 prog addr", prog_addr_o, pa);
            check("R2 prog data", prog_data_o, pd);
            @(negedge clk);
            check("R2 pulse one cycle", prog_pulse_o, 0);
        end

        // R7: mismatches abort the sequence
        wr(19'h05555, 8'hAA); wr(19'h02AAB, 8'h55); wr(19'h05555, 8'h90);
        check("R7 bad key address", id_mode_o, 0);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h54); wr(19'h05555, 8'h90);
        check("R7 bad key data", id_mode_o, 0);
        unlock(4'h0); wr(19'h05555, 8'h77); wr(19'h00100, 8'h11);
        check("R7 unknown opcode", prog_pulse_o, 0);
        unlock(4'h0); wr(19'h05555, 8'h80); wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h54); wr(19'h05555, 8'h10);
        check("R7 bad second key", erase_pulse_o, 0);
        unlock(4'h0); wr(19'h05554, 8'h90);
        check("R7 opcode at wrong address", id_mode_o, 0);

        // R3: identification mode entry and both exits
        unlock(4'h0); wr(19'h05555, 8'h90);
        check("R3 id entry", id_mode_o, 1);
        unlock(4'h0); wr(19'h05555, 8'hF0);
        check("R3 three-write exit", id_mode_o, 0);
        unlock(4'h0); wr(19'h05555, 8'h90);
        check("R3 id re-entry", id_mode_o, 1);
        wr(19'h6ABCD, 8'hF0);
        check("R3 single F0 exit", id_mode_o, 0);
        wr(19'h00000, 8'hF0);
        check("R3 F0 outside id mode", id_mode_o, 0);

        // R6: identification read-back sweep
        unlock(4'h0); wr(19'h05555, 8'h90);
        for (int a = 0; a < 9; a++) begin
            logic [ADDR_W-1:0] ra;
            ra = (a == 8) ? 19'h40000 : ADDR_W'(a);
            rd(ra);
            check("R6 id valid", id_valid_o, 1);
            check("R6 id data", id_data_o, id_expect(ra, 1'b0));
        end
        wr(19'h00003, 8'hF0);
        rd(19'h0);
        check("R6 no read outside id mode", id_valid_o, 0);

        // R4: chip erase
        do_ext(8'h10);
        check("R4 erase pulse", erase_pulse_o, 1);
        check("R4 lock untouched", lock_o, 0);
        @(negedge clk);
        check("R4 erase one cycle", erase_pulse_o, 0);

        // R8: busy masks writes
        busy_i = 1'b1;
        unlock(4'h0);
        busy_i = 1'b0;
        wr(19'h05555, 8'h90);
        check("R8 busy key writes ignored", id_mode_o, 0);
        busy_i = 1'b1;
        do_prog(19'h20000, 8'h3C);
        check("R8 busy program ignored", prog_pulse_o, 0);
        unlock(4'h0); wr(19'h05555, 8'h90);
        check("R8 busy id entry ignored", id_mode_o, 0);
        do_ext(8'h40);
        check("R8 busy lock ignored", lock_o, 0);
        busy_i = 1'b0;

        // R5: boot protection
        do_ext(8'h40);
        check("R5 lock set", lock_o, 1);
        unlock(4'h0); wr(19'h05555, 8'h90);
        rd(19'h2);
        check("R5/R6 lock readback", id_data_o, 8'h01);
        wr(19'h0, 8'hF0);
        for (int k = 0; k < 6; k++) begin
            logic [ADDR_W-1:0] ta;
            case (k)
                0: ta = 19'h00000;
                1: ta = 19'h03FFF;
                2: ta = 19'h04000;
                3: ta = 19'h7C000;
                4: ta = 19'h7FFFF;
                default: ta = 19'h01234;
            endcase
            do_prog(ta, 8'hC3);
            check("R5 boot guard", prog_pulse_o, !in_boot(ta));
        end
        do_ext(8'h10);
        check("R5 lock survives erase", lock_o, 1);
        unlock(4'h0); wr(19'h05555, 8'hF0);
        check("R5 lock survives id exit", lock_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule